// File: doc/BRIEF.md
# Serial TAP Register Access Slave

This block is a serial control slave that reaches a bank of narrow control registers through a test-access-port style state machine. A host drives a serial clock, a mode-select line and a data line. The block walks the sixteen standard TAP states on the rising edge of the serial clock. An instruction scan loads a register address, and a data scan reads or writes one data word at that address. The register bank lives outside the block, behind a simple parallel port with a read pulse, a write pulse, an address and a write word.

Once an address has been loaded, any number of data-only scans can follow without a new address. This suits registers that are rewritten often, such as a channel setting before every packet. A read and a write at the same address are separate events on the port, so an address may hold a read-only register and a distinct write-only register. During the instruction capture, a set of status inputs is loaded and shifted out while the new address is shifted in. The slave must be the only device on its serial bus.

Top module: `tap_regport`

## Requirements
- R1: While `rst_n` is low, the controller is in the reset state regardless of the clock. In that state `rf_addr` is 0, `ser_dout` is 0, and `rf_we` and `rf_re` are 0. This takes effect at once, without a clock edge.
- R2: In the instruction capture state, the instruction shift register loads `status_in`. During the following instruction shift, those bits appear on `ser_dout` least significant bit first.
- R3: The instruction shift takes `ser_din` least significant bit first. `rf_addr` keeps its old value through the instruction update state. It takes the shifted value on the rising edge that leaves the update state.
- R4: The data capture state raises `rf_re` for exactly one serial clock cycle and loads `rf_rdata`. During the following data shift, that byte appears on `ser_dout` least significant bit first.
- R5: The data update state raises `rf_we` for exactly one serial clock cycle. During that cycle `rf_wdata` holds the byte shifted in from `ser_din`, least significant bit first, and `rf_addr` holds the current address.
- R6: Data scans without an instruction scan in between reuse the last loaded address. A read from an address and a write to the same address are separate strobes, so the read data need not equal earlier written data.
- R7: Pausing a shift keeps the shift register contents. The sequence is exit-1, pause (held for any number of cycles), exit-2, then shift again. `ser_dout` is 0 in every state other than the two shift states.
- R8: Going from capture to exit-1 to update without a shift is legal. For data, `rf_we` then carries the captured read byte. For the instruction, the address becomes the captured `status_in` value.
- R9: Five consecutive rising edges with `ser_mode` high reach the reset state from any state and clear `rf_addr` to 0. While the controller is in the reset state, `rf_addr` stays 0.
- R10: `ser_dout` changes only on the falling edge of `ser_clk`. On each rising edge it holds the value set on the falling edge before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Serial control clock |
| ser_mode | input | 1 | Mode select, sampled on the rising edge |
| ser_din | input | 1 | Serial data in, sampled on the rising edge in shift states |
| ser_dout | output | 1 | Serial data out, updated on the falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| status_in | input | ADDR_W | Observability bits loaded by instruction capture |
| rf_addr | output | ADDR_W | Current register address |
| rf_wdata | output | DATA_W | Write word, valid while rf_we is high |
| rf_we | output | 1 | One-cycle write strobe from data update |
| rf_re | output | 1 | One-cycle read strobe from data capture |
| rf_rdata | input | DATA_W | Read word, sampled on the edge that leaves data capture |

## Verification
The bench drives `ser_mode` and `ser_din` just after each falling edge and samples just before the next rising edge. `rf_re` and `rf_we` are due in the sample one tick after the edge that enters capture or update. The new address is due one tick after the update state. Bit k of a captured word is due on `ser_dout` at shift tick k, and it is sampled again just after the rising edge to show it has not moved. The driver tags every expected value with the exact tick number derived from this count, and the monitor compares only when that tick's sample arrives.

// File: rtl/tap_regport_pkg.sv
package tap_regport_pkg;

   typedef enum logic [3:0] {
      S_TLR    = 4'd0,
      S_IDLE   = 4'd1,
      S_SEL_DR = 4'd2,
      S_CAP_DR = 4'd3,
      S_SH_DR  = 4'd4,
      S_EX1_DR = 4'd5,
      S_PS_DR  = 4'd6,
      S_EX2_DR = 4'd7,
      S_UPD_DR = 4'd8,
      S_SEL_IR = 4'd9,
      S_CAP_IR = 4'd10,
      S_SH_IR  = 4'd11,
      S_EX1_IR = 4'd12,
      S_PS_IR  = 4'd13,
      S_EX2_IR = 4'd14,
      S_UPD_IR = 4'd15
   } tap_st_e;

   function automatic tap_st_e tap_next(input tap_st_e cur, input logic m);
      tap_st_e n;
      unique case (cur)
         S_TLR:    n = m ? S_TLR    : S_IDLE;
         S_IDLE:   n = m ? S_SEL_DR : S_IDLE;
         S_SEL_DR: n = m ? S_SEL_IR : S_CAP_DR;
         S_CAP_DR: n = m ? S_EX1_DR : S_SH_DR;
         S_SH_DR:  n = m ? S_EX1_DR : S_SH_DR;
         S_EX1_DR: n = m ? S_UPD_DR : S_PS_DR;
         S_PS_DR:  n = m ? S_EX2_DR : S_PS_DR;
         S_EX2_DR: n = m ? S_UPD_DR : S_SH_DR;
         S_UPD_DR: n = m ? S_SEL_DR : S_IDLE;
         S_SEL_IR: n = m ? S_TLR    : S_CAP_IR;
         S_CAP_IR: n = m ? S_EX1_IR : S_SH_IR;
         S_SH_IR:  n = m ? S_EX1_IR : S_SH_IR;
         S_EX1_IR: n = m ? S_UPD_IR : S_PS_IR;
         S_PS_IR:  n = m ? S_EX2_IR : S_PS_IR;
         S_EX2_IR: n = m ? S_UPD_IR : S_SH_IR;
         S_UPD_IR: n = m ? S_SEL_DR : S_IDLE;
         default:  n = S_TLR;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
   import tap_regport_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    mode,
   output tap_st_e st,
   output tap_st_e nxt
);

   always_comb nxt = tap_next(st, mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= S_TLR;
      else        st <= nxt;
   end

endmodule

// File: rtl/tap_sreg.sv
module tap_sreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic         shf,
   input  logic [W-1:0] cap_val,
   input  logic         sdi,
   output logic [W-1:0] q
);

   logic [W-1:0] shifted;

   generate
      if (W == 1) begin : g_single
         always_comb shifted = sdi;
      end else begin : g_multi
         always_comb shifted = {sdi, q[W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (cap) q <= cap_val;
      else if (shf) q <= shifted;
   end

endmodule

// File: rtl/tap_dout.sv
module tap_dout #(
   parameter bit ON_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic bit_in,
   output logic dout
);

   logic nxt_bit;

   always_comb nxt_bit = en & bit_in;

   generate
      if (ON_FALL) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) dout <= 1'b0;
            else        dout <= nxt_bit;
         end
      end else begin : g_comb
         always_comb dout = nxt_bit;
      end
   endgenerate

endmodule

// File: rtl/tap_regport.sv
module tap_regport
   import tap_regport_pkg::*;
#(
   parameter int ADDR_W       = 5,
   parameter int DATA_W       = 8,
   parameter bit DOUT_ON_FALL = 1'b1
) (
   input  logic              ser_clk,
   input  logic              ser_mode,
   input  logic              ser_din,
   output logic              ser_dout,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] status_in,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              rf_we,
   output logic              rf_re,
   input  logic [DATA_W-1:0] rf_rdata
);

   localparam logic [ADDR_W-1:0] ADDR_CLR = '0;

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("tap_regport: ADDR_W must lie in 1..16");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data_w
         $error("tap_regport: DATA_W must lie in 1..64");
      end
   endgenerate

   tap_st_e st;
   tap_st_e nxt;

   logic [ADDR_W-1:0] ir_q;
   logic [DATA_W-1:0] dr_q;
   logic              ir_cap, ir_shf, dr_cap, dr_shf;
   logic              in_shift, out_bit;
   logic [ADDR_W-1:0] addr_q;

   tap_ctrl u_ctrl (
      .clk   (ser_clk),
      .rst_n (rst_n),
      .mode  (ser_mode),
      .st    (st),
      .nxt   (nxt)
   );

   always_comb begin
      ir_cap   = (st == S_CAP_IR);
      ir_shf   = (st == S_SH_IR);
      dr_cap   = (st == S_CAP_DR);
      dr_shf   = (st == S_SH_DR);
      in_shift = ir_shf | dr_shf;
      out_bit  = ir_shf ? ir_q[0] : dr_q[0];
   end

   tap_sreg #(.W(ADDR_W)) u_ir (
      .clk     (ser_clk),
      .rst_n   (rst_n),
      .cap     (ir_cap),
      .shf     (ir_shf),
      .cap_val (status_in),
      .sdi     (ser_din),
      .q       (ir_q)
   );

   tap_sreg #(.W(DATA_W)) u_dr (
      .clk     (ser_clk),
      .rst_n   (rst_n),
      .cap     (dr_cap),
      .shf     (dr_shf),
      .cap_val (rf_rdata),
      .sdi     (ser_din),
      .q       (dr_q)
   );

   tap_dout #(.ON_FALL(DOUT_ON_FALL)) u_out (
      .clk    (ser_clk),
      .rst_n  (rst_n),
      .en     (in_shift),
      .bit_in (out_bit),
      .dout   (ser_dout)
   );

   always_ff @(posedge ser_clk or negedge rst_n) begin
      if (!rst_n)               addr_q <= ADDR_CLR;
      else if (nxt == S_TLR)    addr_q <= ADDR_CLR;
      else if (st == S_UPD_IR)  addr_q <= ir_q;
   end

   always_comb begin
      rf_addr  = addr_q;
      rf_wdata = dr_q;
      rf_we    = (st == S_UPD_DR);
      rf_re    = (st == S_CAP_DR);
   end

endmodule

// File: rtl/tap_regport_chk.sv
module tap_regport_chk
   import tap_regport_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8
) (
   input logic              ser_clk,
   input logic              rst_n,
   input logic              ser_mode,
   input logic              ser_dout,
   input tap_st_e           st,
   input logic [ADDR_W-1:0] ir_q,
   input logic [ADDR_W-1:0] rf_addr,
   input logic              rf_we,
   input logic              rf_re
);

   // R5: write strobe lasts one cycle
   p_we_pulse_r5: assert property (@(posedge ser_clk) disable iff (!rst_n)
      rf_we |=> !rf_we);

   // R4: read strobe lasts one cycle
   p_re_pulse_r4: assert property (@(posedge ser_clk) disable iff (!rst_n)
      rf_re |=> !rf_re);

   // R3: address moves only out of the instruction update state or into reset
   p_addr_hold_r3: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (st != S_UPD_IR && !(st == S_SEL_IR && ser_mode)) |=> $stable(rf_addr));

   // R3: address takes the shifted instruction on leaving update
   p_addr_load_r3: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (st == S_UPD_IR) |=> (rf_addr == $past(ir_q)));

   // R7: serial output is quiet outside the shift states
   p_dout_quiet_r7: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (st != S_SH_IR && st != S_SH_DR) |-> (ser_dout == 1'b0));

   // R9: address is zero while in the reset state
   p_tlr_clear_r9: assert property (@(posedge ser_clk) disable iff (!rst_n)
      (st == S_TLR) |-> (rf_addr == '0));

endmodule

bind tap_regport tap_regport_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .ser_clk  (ser_clk),
   .rst_n    (rst_n),
   .ser_mode (ser_mode),
   .ser_dout (ser_dout),
   .st       (st),
   .ir_q     (ir_q),
   .rf_addr  (rf_addr),
   .rf_we    (rf_we),
   .rf_re    (rf_re)
);

// File: tb/tap_regport_tb.sv
module tap_regport_tb;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int AW = 5;
   localparam int DW = 8;
   localparam logic [AW-1:0] SPLIT_A  = 5'd9;
   localparam logic [DW-1:0] SPLIT_RD = 8'hA5;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          ser_mode = 1'b0, ser_din = 1'b0, rst_n = 1'b0;
   logic          ser_dout, rf_we, rf_re;
   logic [AW-1:0] status_in = '0;
   logic [AW-1:0] rf_addr;
   logic [DW-1:0] rf_wdata, rf_rdata;

   tap_regport #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .ser_clk(clk), .ser_mode(ser_mode), .ser_din(ser_din), .ser_dout(ser_dout),
      .rst_n(rst_n), .status_in(status_in), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
      .rf_we(rf_we), .rf_re(rf_re), .rf_rdata(rf_rdata)
   );

   // register bank seen by the design, and the bench's own expectation of it
   logic [DW-1:0] rf_mem [32];
   logic [DW-1:0] shadow [32];
   logic [AW-1:0] cur_a = '0;

   always_comb rf_rdata = (rf_addr == SPLIT_A) ? SPLIT_RD : rf_mem[rf_addr];
   always @(posedge clk) if (rf_we) rf_mem[rf_addr] <= rf_wdata;

   typedef enum {F_DOUT, F_DOUTP, F_WE, F_RE, F_ADDR, F_WDATA} fld_e;
   typedef struct {int tick; fld_e f; logic [7:0] v; string tag;} item_t;
   item_t q[$];

   int tick_no = 0, n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [7:0] o_dout, o_doutp, o_we, o_re, o_addr, o_wdata;
   event smp_ev;

   task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h (tick %0d)", tag, what, act, exp, tick_no);
      end
   endtask

   task automatic expect_at(input fld_e f, input logic [7:0] v, input string tag);
      item_t it;
      it.tick = tick_no + 1; it.f = f; it.v = v; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic tick(input logic m, input logic d);
      @(negedge clk);
      #0.5 ser_mode = m; ser_din = d;
      #1.5;
      o_dout = {7'd0, ser_dout}; o_we = {7'd0, rf_we}; o_re = {7'd0, rf_re};
      o_addr = {3'd0, rf_addr};  o_wdata = rf_wdata;
      #1 o_doutp = {7'd0, ser_dout};
      tick_no++;
      -> smp_ev;
   endtask

   // monitor: pops expected items as their tick's sample arrives
   initial begin
      forever begin
         @(smp_ev);
         while (q.size() > 0 && q[0].tick <= tick_no) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.f)
               F_DOUT:  act = o_dout;
               F_DOUTP: act = o_doutp;
               F_WE:    act = o_we;
               F_RE:    act = o_re;
               F_ADDR:  act = o_addr;
               default: act = o_wdata;
            endcase
            check(it.tag, it.f.name(), act, it.v);
         end
      end
   end

   function automatic logic [7:0] exp_read(input logic [AW-1:0] a);
      return (a == SPLIT_A) ? SPLIT_RD : shadow[a];
   endfunction

   task automatic shift_bits(input logic [7:0] rd, input logic [7:0] wd, input int lo, input int hi, input string tag);
      for (int k = lo; k <= hi; k++) begin
         expect_at(F_DOUT, {7'd0, rd[k]}, tag);
         expect_at(F_DOUTP, {7'd0, rd[k]}, "R10");
         tick(k == hi, wd[k]);
      end
   endtask

   task automatic finish_dr(input logic [7:0] wd, input string tag);
      expect_at(F_DOUT, 8'd0, "R7");
      tick(1'b1, 1'b0);                       // exit-1 -> update
      expect_at(F_WE, 8'd1, "R5");
      expect_at(F_WDATA, wd, tag);
      expect_at(F_ADDR, {3'd0, cur_a}, "R6");
      tick(1'b0, 1'b0);                       // update -> idle
      expect_at(F_WE, 8'd0, "R5");
      tick(1'b0, 1'b0);
      if (cur_a != SPLIT_A) shadow[cur_a] = wd;
   endtask

   task automatic dr_scan(input logic [7:0] wd, input string tag);
      logic [7:0] rd;
      rd = exp_read(cur_a);
      tick(1'b1, 1'b0);
      tick(1'b0, 1'b0);                       // -> capture
      expect_at(F_RE, 8'd1, "R4");
      tick(1'b0, 1'b0);                       // capture -> shift
      expect_at(F_RE, 8'd0, "R4");
      shift_bits(rd, wd, 0, 7, tag);
      finish_dr(wd, "R5");
   endtask

   task automatic dr_pause(input logic [7:0] wd);
      logic [7:0] rd;
      rd = exp_read(cur_a);
      tick(1'b1, 1'b0);
      tick(1'b0, 1'b0);
      tick(1'b0, 1'b0);
      shift_bits(rd, wd, 0, 3, "R7");
      tick(1'b0, 1'b0);                       // exit-1 -> pause
      expect_at(F_DOUT, 8'd0, "R7");
      tick(1'b0, 1'b0);                       // stay in pause
      expect_at(F_DOUT, 8'd0, "R7");
      tick(1'b1, 1'b0);                       // -> exit-2
      tick(1'b0, 1'b0);                       // -> shift
      shift_bits(rd, wd, 4, 7, "R7");
      finish_dr(wd, "R7");
   endtask

   task automatic dr_skip();
      logic [7:0] rd;
      rd = exp_read(cur_a);
      tick(1'b1, 1'b0);
      tick(1'b0, 1'b0);                       // -> capture
      tick(1'b1, 1'b0);                       // capture -> exit-1
      tick(1'b1, 1'b0);                       // -> update
      expect_at(F_WE, 8'd1, "R8");
      expect_at(F_WDATA, rd, "R8");
      tick(1'b0, 1'b0);
      tick(1'b0, 1'b0);
      if (cur_a != SPLIT_A) shadow[cur_a] = rd;
   endtask

   task automatic ir_scan(input logic [AW-1:0] na);
      logic [AW-1:0] sv;
      sv = status_in;
      tick(1'b1, 1'b0);
      tick(1'b1, 1'b0);
      tick(1'b0, 1'b0);                       // -> capture
      tick(1'b0, 1'b0);                       // capture -> shift
      for (int k = 0; k < AW; k++) begin
         expect_at(F_DOUT, {7'd0, sv[k]}, "R2");
         tick(k == AW - 1, na[k]);
      end
      tick(1'b1, 1'b0);                       // -> update
      expect_at(F_ADDR, {3'd0, cur_a}, "R3");
      tick(1'b0, 1'b0);                       // update -> idle, address loads
      expect_at(F_ADDR, {3'd0, na}, "R3");
      tick(1'b0, 1'b0);
      cur_a = na;
   endtask

   task automatic ir_skip();
      logic [AW-1:0] sv;
      sv = status_in;
      tick(1'b1, 1'b0);
      tick(1'b1, 1'b0);
      tick(1'b0, 1'b0);                       // -> capture
      tick(1'b1, 1'b0);                       // capture -> exit-1
      tick(1'b1, 1'b0);                       // -> update
      tick(1'b0, 1'b0);
      expect_at(F_ADDR, {3'd0, sv}, "R8");
      tick(1'b0, 1'b0);
      cur_a = sv;
   endtask

   task automatic five_ones();
      logic [7:0] rd;
      rd = exp_read(cur_a);
      tick(1'b1, 1'b0);
      tick(1'b0, 1'b0);
      tick(1'b0, 1'b0);                       // now in data shift
      tick(1'b1, 1'b1);                       // one 1: shift in a 1
      tick(1'b1, 1'b0);                       // two
      tick(1'b1, 1'b0);                       // three
      tick(1'b1, 1'b0);                       // four
      expect_at(F_ADDR, {3'd0, cur_a}, "R9");
      tick(1'b1, 1'b0);                       // five
      expect_at(F_ADDR, 8'd0, "R9");
      expect_at(F_WE, 8'd0, "R9");
      tick(1'b0, 1'b0);
      if (cur_a != SPLIT_A) shadow[cur_a] = {1'b1, rd[7:1]};
      cur_a = '0;
      tick(1'b0, 1'b0);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) begin
         rf_mem[i] = 8'(i * 8'h11) ^ 8'h3C;
         shadow[i] = 8'(i * 8'h11) ^ 8'h3C;
      end
      // R1: held in reset
      expect_at(F_ADDR, 8'd0, "R1");
      expect_at(F_DOUT, 8'd0, "R1");
      expect_at(F_WE, 8'd0, "R1");
      expect_at(F_RE, 8'd0, "R1");
      tick(1'b1, 1'b1);
      tick(1'b1, 1'b1);
      rst_n = 1'b1;
      tick(1'b0, 1'b0);                       // -> idle

      status_in = 5'h16;
      ir_scan(5'h03);
      dr_scan(8'h5C, "R4");
      dr_scan(8'hE1, "R6");                   // data-only, reads back 5C
      status_in = 5'h09;
      ir_scan(SPLIT_A);
      dr_scan(8'h3F, "R6");
      dr_scan(8'h77, "R6");                   // split: read stays A5
      ir_scan(5'h1E);
      dr_pause(8'h96);
      dr_scan(8'h00, "R7");                   // reads back 96 after pause
      dr_skip();
      status_in = 5'h11;
      ir_skip();
      dr_scan(8'hFF, "R8");
      five_ones();
      tick(1'b0, 1'b0);
      ir_scan(5'h0C);

      // R1: asynchronous reset mid-run
      @(negedge clk);
      #1 rst_n = 1'b0;
      #0.5;
      check("R1", "addr_async", {3'd0, rf_addr}, 8'd0);
      check("R1", "dout_async", {7'd0, ser_dout}, 8'd0);
      cur_a = '0;
      tick(1'b0, 1'b0);
      rst_n = 1'b1;
      tick(1'b0, 1'b0);
      dr_scan(8'h42, "R1");
      tick(1'b0, 1'b0);

      n_chk++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5ns * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule